// File: doc/BRIEF.md
# Indexed Microprocessor Bus Interface

This block is the host-side bus slave of a chip that exposes 256 bytes of internal storage through an 8-bit data bus. It is driven by an external processor through asynchronous strobes: chip select, write, read and a single address line. Every bus input is brought into the system clock through two-flop synchronisers, and all decisions are made there. On the other side the block drives a simple memory port: address, write data, a write enable, a read enable and the read data coming back. It also raises a strobe whenever a write lands in the register part of the storage.

The lower 64 locations (0x00–0x3F) are control, status and endpoint registers. The upper 192 (0x40–0xFF) are data buffer. In indexed mode the processor first writes a target address with the address line low. That value goes into an address latch. Any later access with the address line high uses the latched location, and the latch keeps its value afterwards. In direct mode a full 8-bit address is supplied on a side input and the address line is ignored.

A write ends when its window closes, that is, when either chip select or write returns high, whichever comes first. The data seen last inside the window is what gets stored. Hosts that release chip select before the write strobe therefore behave the same as hosts that release the write strobe first.

Top module: `mpu_idx_bus`

## Requirements
- R1: After reset the address latch is 0x00, mem_we is low and bus_doe is low.
- R2: In indexed mode (direct_sel low), a write with bus_a0 low loads the written byte into the address latch and produces no memory write.
- R3: In indexed mode, a write with bus_a0 high produces exactly one single-cycle mem_we pulse, with mem_addr equal to the latched address and mem_wdata equal to the written byte.
- R4: The address latch is unchanged by data accesses, so repeated bus_a0-high writes target the same location.
- R5: A write whose bus_cs_n rises while bus_wr_n is still low ends at the bus_cs_n rise, and produces one memory write only.
- R6: A write whose bus_wr_n rises while bus_cs_n is still low ends at the bus_wr_n rise, and produces one memory write.
- R7: In direct mode (direct_sel high) a write targets direct_addr regardless of bus_a0, and leaves the address latch untouched.
- R8: bus_doe is high only while bus_cs_n and bus_rd_n are both low, after two clocks of synchroniser delay. During such a read with bus_a0 high, bus_dout equals the stored byte at the target address.
- R9: reg_wr_stb is high together with mem_we exactly when the write address is below 0x40.
- R10: In indexed mode, a read with bus_a0 low returns the address latch on bus_dout.
- R11: Data bus changes made as the write window closes, or after it, do not alter the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| direct_sel | input | 1 | 1 = direct addressing, 0 = indexed |
| direct_addr | input | 8 | Full address used in direct mode |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_a0 | input | 1 | Address line: 0 = address latch, 1 = data |
| bus_din | input | 8 | Data bus, host to block |
| bus_dout | output | 8 | Data bus, block to host |
| bus_doe | output | 1 | Drive enable for bus_dout |
| mem_addr | output | 8 | Storage address |
| mem_wdata | output | 8 | Storage write data |
| mem_we | output | 1 | Storage write enable, one-cycle pulse |
| mem_re | output | 1 | Storage read enable |
| mem_rdata | input | 8 | Storage read data |
| reg_wr_stb | output | 1 | Write into the register region (below 0x40) |

## Verification
Writes are driven with the two release orders: write strobe first and chip select first. Comparing them shows whether the end of the cycle is taken from either signal and whether a single write results. In one chip-select-first write the data bus is flipped at the moment of release, which shows whether the stored byte comes from inside the window. Latch loads alternate with data writes to 0x3F and 0x40, which checks the region boundary of the register strobe and that the latch persists. A direct-mode write followed by an indexed latch read shows that direct mode bypasses the latch.

// File: rtl/mpu_bus_pkg.sv
package mpu_bus_pkg;
  localparam int DW        = 8;
  localparam int AW        = 8;
  localparam int REG_SPACE = 64;
  localparam int SYNC_STG  = 2;

  typedef struct packed {
    logic          cs_n;
    logic          wr_n;
    logic          rd_n;
    logic          a0;
    logic [DW-1:0] data;
    logic [AW-1:0] daddr;
  } bus_smp_t;

  localparam int SMP_W = $bits(bus_smp_t);
endpackage

// File: rtl/mpu_bus_sync.sv
module mpu_bus_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [W-1:0] stg_d;
    if (i == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_next
      assign stg_d = stg_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= RST_VAL;
      else        stg_q[i] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/mpu_bus_term.sv
module mpu_bus_term
  import mpu_bus_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  bus_smp_t      smp,
  output logic          wr_end,
  output logic [DW-1:0] hold_data,
  output logic          hold_a0,
  output logic [AW-1:0] hold_daddr
);
  logic          act;
  logic          act_q;
  logic [DW-1:0] data_q,  data_d;
  logic          a0_q,    a0_d;
  logic [AW-1:0] daddr_q, daddr_d;

  assign act = ~smp.cs_n & ~smp.wr_n;

  always_comb begin
    data_d  = data_q;
    a0_d    = a0_q;
    daddr_d = daddr_q;
    if (act) begin
      data_d  = smp.data;
      a0_d    = smp.a0;
      daddr_d = smp.daddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      data_q  <= '0;
      a0_q    <= 1'b0;
      daddr_q <= '0;
    end else begin
      act_q   <= act;
      data_q  <= data_d;
      a0_q    <= a0_d;
      daddr_q <= daddr_d;
    end
  end

  assign wr_end     = act_q & ~act;
  assign hold_data  = data_q;
  assign hold_a0    = a0_q;
  assign hold_daddr = daddr_q;
endmodule

// File: rtl/mpu_idx_bus.sv
module mpu_idx_bus
  import mpu_bus_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          direct_sel,
  input  logic [AW-1:0] direct_addr,
  input  logic          bus_cs_n,
  input  logic          bus_wr_n,
  input  logic          bus_rd_n,
  input  logic          bus_a0,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          reg_wr_stb
);
  localparam bus_smp_t SMP_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1,
                                    a0: 1'b0, data: '0, daddr: '0};

  logic     rst_core_n;
  bus_smp_t raw, smp;
  logic     wr_end, hold_a0;
  logic [DW-1:0] hold_data;
  logic [AW-1:0] hold_daddr;

  logic [AW-1:0] idx_q, idx_d;
  logic          we_q, we_d;
  logic [AW-1:0] waddr_q, waddr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic          load_idx, do_wr, rd_act, data_sel;
  logic [AW-1:0] rd_addr;

  mpu_bus_sync #(.W(1), .STAGES(SYNC_STG), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_core_n));

  assign raw = '{cs_n: bus_cs_n, wr_n: bus_wr_n, rd_n: bus_rd_n,
                 a0: bus_a0, data: bus_din, daddr: direct_addr};

  mpu_bus_sync #(.W(SMP_W), .STAGES(SYNC_STG), .RST_VAL(SMP_IDLE)) u_bus_sync (
    .clk(clk), .rst_n(rst_core_n), .d(raw), .q(smp));

  mpu_bus_term u_term (
    .clk(clk), .rst_n(rst_core_n), .smp(smp), .wr_end(wr_end),
    .hold_data(hold_data), .hold_a0(hold_a0), .hold_daddr(hold_daddr));

  assign load_idx = wr_end & ~direct_sel & ~hold_a0;
  assign do_wr    = wr_end & (direct_sel | hold_a0);

  always_comb begin
    idx_d   = idx_q;
    we_d    = do_wr;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    if (load_idx) idx_d = hold_data;
    if (do_wr) begin
      waddr_d = direct_sel ? hold_daddr : idx_q;
      wdata_d = hold_data;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      idx_q   <= '0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      idx_q   <= idx_d;
      we_q    <= we_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  assign rd_act   = ~smp.cs_n & ~smp.rd_n;
  assign data_sel = direct_sel | smp.a0;
  assign rd_addr  = direct_sel ? smp.daddr : idx_q;

  assign mem_addr   = we_q ? waddr_q : rd_addr;
  assign mem_wdata  = wdata_q;
  assign mem_we     = we_q;
  assign mem_re     = rd_act & data_sel & ~we_q;
  assign bus_doe    = rd_act;
  assign bus_dout   = data_sel ? mem_rdata : idx_q;
  assign reg_wr_stb = we_q & (waddr_q < AW'(REG_SPACE));
endmodule

// File: rtl/mpu_idx_bus_chk.sv
module mpu_idx_bus_chk
  import mpu_bus_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          bus_cs_n,
  input logic          bus_wr_n,
  input logic          bus_rd_n,
  input logic          bus_doe,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          reg_wr_stb,
  input logic [AW-1:0] idx_q
);
  logic [3:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cyc <= '0;
    else if (cyc != 4'hF) cyc <= cyc + 4'd1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 4'd0) |-> (!mem_we && !bus_doe && idx_q == '0));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 4'd2 && mem_we) |-> $stable(idx_q));

  a_r5_write_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 4'd8 && mem_we) |->
      ($past(bus_cs_n | bus_wr_n, 3) && $past(!bus_cs_n && !bus_wr_n, 4)));

  a_r8_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 4'd6) |-> (bus_doe == $past(!bus_cs_n && !bus_rd_n, 2)));

  a_r9_reg_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_stb |-> (mem_we && mem_addr < AW'(REG_SPACE)));
endmodule

bind mpu_idx_bus mpu_idx_bus_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
  .bus_rd_n(bus_rd_n), .bus_doe(bus_doe), .mem_we(mem_we),
  .mem_addr(mem_addr), .reg_wr_stb(reg_wr_stb), .idx_q(idx_q));

// File: tb/mpu_idx_bus_test.sv
module mpu_idx_bus_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       direct_sel = 1'b0;
  logic [7:0] direct_addr = 8'h00;
  logic       bus_cs_n = 1'b1, bus_wr_n = 1'b1, bus_rd_n = 1'b1, bus_a0 = 1'b0;
  logic [7:0] bus_din = 8'h00;
  logic [7:0] bus_dout, mem_addr, mem_wdata, mem_rdata;
  logic       bus_doe, mem_we, mem_re, reg_wr_stb;

  logic [7:0] store  [256];
  logic [7:0] shadow [256];
  logic [7:0] latch_m = 8'h00;
  logic [16:0] sbq [$];
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mpu_idx_bus uut (
    .clk(clk), .rst_n(rst_n), .direct_sel(direct_sel), .direct_addr(direct_addr),
    .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_a0(bus_a0),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .reg_wr_stb(reg_wr_stb));

  assign mem_rdata = store[mem_addr];
  always @(posedge clk) if (mem_we) store[mem_addr] <= mem_wdata;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected {strobe, addr, data}
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (sbq.size() == 0) begin
        tests++; fails++;
        $display("FAIL R2/R5: actual unexpected write %h@%h expected none", mem_wdata, mem_addr);
      end else begin
        logic [16:0] e;
        e = sbq.pop_front();
        chk("R3 write addr", {8'h00, mem_addr}, {8'h00, e[15:8]});
        chk("R11 write data", {8'h00, mem_wdata}, {8'h00, e[7:0]});
        chk("R9 reg strobe", {15'h0, reg_wr_stb}, {15'h0, e[16]});
      end
    end
  end

  task automatic bus_write(input logic a0, input logic [7:0] d, input bit cs_first,
                           input bit flip);
    logic [7:0] ta;
    if (direct_sel || a0) begin
      ta = direct_sel ? direct_addr : latch_m;
      sbq.push_back({ta < 8'h40, ta, d});
      shadow[ta] = d;
    end else begin
      latch_m = d;
    end
    @(negedge clk); bus_a0 = a0; bus_din = d; bus_cs_n = 1'b0;
    @(negedge clk); bus_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    if (cs_first) begin
      bus_cs_n = 1'b1;
      if (flip) bus_din = ~d;
      @(negedge clk); bus_wr_n = 1'b1;
    end else begin
      bus_wr_n = 1'b1;
      @(negedge clk); bus_cs_n = 1'b1;
    end
    if (flip) bus_din = ~d;
    repeat (6) @(negedge clk);
    chk("R3/R5 write drained", {15'h0, sbq.size() != 0}, 16'h0);
  endtask

  task automatic bus_read(input logic a0, input logic [7:0] exp, input string req);
    @(negedge clk); bus_a0 = a0; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 drive on", {15'h0, bus_doe}, 16'h1);
    chk(req, {8'h00, bus_dout}, {8'h00, exp});
    bus_rd_n = 1'b1; bus_cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 drive off", {15'h0, bus_doe}, 16'h0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin store[i] = 8'h00; shadow[i] = 8'h00; end
    repeat (4) @(negedge clk);
    chk("R1 mem_we at reset", {15'h0, mem_we}, 16'h0);
    chk("R1 doe at reset", {15'h0, bus_doe}, 16'h0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 doe after reset", {15'h0, bus_doe}, 16'h0);
    bus_read(1'b0, 8'h00, "R1 latch reset value");

    bus_write(1'b0, 8'h45, 1'b0, 1'b0);               // R2 latch load
    bus_read(1'b0, 8'h45, "R10 latch readback");
    bus_write(1'b1, 8'hA5, 1'b0, 1'b0);               // R6 wr-first
    bus_write(1'b1, 8'h3C, 1'b1, 1'b0);               // R5 cs-first, R4 same addr
    bus_read(1'b1, shadow[8'h45], "R8 read data");
    bus_read(1'b0, 8'h45, "R4 latch held");

    bus_write(1'b0, 8'h3F, 1'b0, 1'b0);
    bus_write(1'b1, 8'h11, 1'b0, 1'b0);               // R9 top of register region
    bus_write(1'b0, 8'h40, 1'b1, 1'b0);
    bus_write(1'b1, 8'h22, 1'b1, 1'b0);               // R9 first buffer byte
    bus_write(1'b1, 8'h77, 1'b1, 1'b1);               // R11 data flip at release
    bus_read(1'b1, shadow[8'h40], "R11 stored byte");

    direct_sel = 1'b1; direct_addr = 8'h90;
    bus_write(1'b0, 8'h5A, 1'b0, 1'b0);               // R7 a0 ignored
    direct_addr = 8'h12;
    bus_write(1'b1, 8'h6B, 1'b1, 1'b0);               // R7, R9
    bus_read(1'b0, shadow[8'h12], "R7 direct read");
    direct_sel = 1'b0;
    repeat (2) @(negedge clk);
    bus_read(1'b0, 8'h40, "R7 latch untouched");
    bus_read(1'b1, shadow[8'h40], "R8 indexed read");

    chk("R3 queue empty at end", {15'h0, sbq.size() != 0}, 16'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule